// File: doc/BRIEF.md
# I2C SCL Clock Timing Generator

This block makes the serial clock for an I2C master from the system clock. The timing has three parts. A power-of-two prescaler turns the system clock into base ticks. Two small counters then set how many base ticks SCL stays low and how many it stays high. The timing comes from one of two sources. The first is a packed timing word. The second is a raw divider ratio, which is the system clock rate divided by the wanted bus rate. A conversion path turns that ratio into the same three fields. It halves the ratio until it fits the counters and rounds up when it loses precision.

The master engine raises the enable while it needs bit clocks. When the enable drops, SCL is released. Two one-cycle strobes mark the moment SCL is released high and the moment it is pulled low. The engine uses them to sample SDA and to change SDA. The block also reads back the SCL line. If a slave holds the line low during the high phase, the high phase is stretched by exactly that long.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is high, or while the block is idle with enable low, `scl_o` is 1 and both strobes are 0.
- R2: When `sel_ratio` is 0, the timing comes from `tim_word`. Bits [3:0] hold the base exponent e. Bits [7:4] hold the low count lo. Bits [11:8] hold the high count hi.
- R3: On the clock edge that first samples `en` high, `scl_o` goes to 0 and `fall_stb` pulses. SCL then stays low for (lo+1)·2^e system cycles.
- R4: When no slave is stretching the clock, SCL stays high for (hi+1)·2^e system cycles. Then it goes low again and the low/high cycle repeats while `en` stays high.
- R5: `rise_stb` is high only in the first cycle in which `scl_o` is 1 after being 0. `fall_stb` is high only in the first cycle in which `scl_o` is 0. Each strobe lasts one cycle.
- R6: When `sel_ratio` is 1, the block converts the ratio. It halves the ratio while the ratio is 16 or more, and each halving adds one to e. If any bit shifted out was 1, it adds one to the reduced ratio r.
- R7: From r (ratios below 4 count as 4), lo = r/2 − 1 (integer division) and hi = r − lo − 2. So one period lasts r·2^e cycles, and hi is lo or lo+1.
- R8: During the high phase, each cycle in which `scl_in` is sampled low adds one cycle to the high time. A low `scl_in` during the low phase has no effect.
- R9: The timing source is captured only while the block is idle. Changes to `tim_word`, `ratio` or `sel_ratio` while `en` stays high do not change the running waveform.
- R10: On the edge that samples `en` low, the block goes idle and `scl_o` becomes 1. If SCL was low, `rise_stb` pulses in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Request bit clocks from the generator |
| sel_ratio | input | 1 | 1: use `ratio`; 0: use `tim_word` |
| tim_word | input | 12 | Packed timing: [11:8] high count, [7:4] low count, [3:0] exponent |
| ratio | input | RATIO_W (16) | Raw divider ratio, system clock over bus rate |
| scl_in | input | 1 | SCL line read back (low while a slave stretches) |
| scl_o | output | 1 | SCL drive: 1 releases the line, 0 pulls it low |
| rise_stb | output | 1 | One-cycle pulse when SCL is released high |
| fall_stb | output | 1 | One-cycle pulse when SCL is pulled low |

## Verification
Each internal error shows up in a different place. A prescaler that wraps at the wrong value, or a phase counter with a wrong terminal value, makes the low or high time too long or too short. The bench measures both, so this shows within the first SCL period after enable. A conversion fault in the halving, the sticky rounding or the clamp changes the measured low and high times for the specific ratios that hit that fault, such as 15, 16, 17, 31 and values below 4. A strobe out of step with `scl_o`, a stretch counted in the wrong phase, or timing that follows its inputs while running shows up as wrong strobe values or wrong phase lengths, sampled right at the phase boundary.

// File: rtl/scl_tim_pkg.sv
package scl_tim_pkg;
  localparam int CNT_W  = 4;
  localparam int EXP_W  = 4;
  localparam int WORD_W = 2 * CNT_W + EXP_W;
  localparam int PRE_W  = (1 << EXP_W) - 1;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
    logic [EXP_W-1:0] ex;
  } tim_cfg_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_t;
endpackage

// File: rtl/scl_ratio_pack.sv
module scl_ratio_pack
  import scl_tim_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic [RATIO_W-1:0] ratio,
  output tim_cfg_t           cfg
);
  logic [RATIO_W-1:0] r;
  logic [EXP_W-1:0]   e;
  logic               sticky;
  logic [4:0]         red;

  // Halve until the value fits the counters; remember lost ones for rounding.
  always_comb begin
    r      = ratio;
    e      = '0;
    sticky = 1'b0;
    for (int i = 0; i < RATIO_W; i++) begin
      if (r >= RATIO_W'(16)) begin
        sticky = sticky | r[0];
        r      = r >> 1;
        e      = e + EXP_W'(1);
      end
    end
    red = {1'b0, r[3:0]} + {4'd0, sticky};
    if (red < 5'd4) red = 5'd4;
    cfg.ex = e;
    cfg.lo = CNT_W'(red[4:1] - 4'd1);
    cfg.hi = CNT_W'(red[4:1] + {3'd0, red[0]} - 4'd1);
  end
endmodule

// File: rtl/scl_base_tick.sv
module scl_base_tick
  import scl_tim_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             hold,
  input  logic [EXP_W-1:0] ex,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] limit;

  assign limit = ~({PRE_W{1'b1}} << ex);
  assign tick  = run && !hold && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!hold)  cnt <= tick ? '0 : cnt + PRE_W'(1);
  end

  assert_pre_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= limit));
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_tim_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     tick,
  input  logic     scl_in,
  input  tim_cfg_t cfg,
  output logic     run,
  output logic     hold,
  output logic     idle,
  output logic     scl_q,
  output logic     rise_q,
  output logic     fall_q
);
  phase_t           phase;
  logic [CNT_W-1:0] cnt;

  assign run  = (phase != PH_IDLE);
  assign idle = (phase == PH_IDLE);
  assign hold = (phase == PH_HIGH) && !scl_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      scl_q  <= 1'b1;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (!en) begin
        phase <= PH_IDLE;
        cnt   <= '0;
        scl_q <= 1'b1;
        if (!scl_q) rise_q <= 1'b1;
      end else begin
        case (phase)
          PH_IDLE: begin
            phase  <= PH_LOW;
            scl_q  <= 1'b0;
            fall_q <= 1'b1;
            cnt    <= '0;
          end
          PH_LOW: if (tick) begin
            if (cnt == cfg.lo) begin
              phase  <= PH_HIGH;
              scl_q  <= 1'b1;
              rise_q <= 1'b1;
              cnt    <= '0;
            end else cnt <= cnt + CNT_W'(1);
          end
          PH_HIGH: if (tick) begin
            if (cnt == cfg.hi) begin
              phase  <= PH_LOW;
              scl_q  <= 1'b0;
              fall_q <= 1'b1;
              cnt    <= '0;
            end else cnt <= cnt + CNT_W'(1);
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(rise_q && fall_q));
  assert_rise_on_edge_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_q) |-> rise_q);
  assert_fall_on_edge_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_q) |-> fall_q);
  assert_low_count_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOW) |-> (cnt <= cfg.lo));
  assert_stretch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (en && phase == PH_HIGH && !scl_in) |=> (scl_q && $stable(cnt)));
  assert_release_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (scl_q && !fall_q));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tim_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               sel_ratio,
  input  logic [WORD_W-1:0]  tim_word,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               scl_in,
  output logic               scl_o,
  output logic               rise_stb,
  output logic               fall_stb
);
  tim_cfg_t pk_cfg;
  tim_cfg_t cfg_q;
  logic     tick, run, hold, idle;

  scl_ratio_pack #(.RATIO_W(RATIO_W)) u_pack (
    .ratio (ratio),
    .cfg   (pk_cfg)
  );

  // Timing source is captured only between transfers.
  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= '0;
    else if (idle) cfg_q <= sel_ratio ? pk_cfg : tim_cfg_t'(tim_word);
  end

  scl_base_tick u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .hold (hold),
    .ex   (cfg_q.ex),
    .tick (tick)
  );

  scl_phase_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .tick   (tick),
    .scl_in (scl_in),
    .cfg    (cfg_q),
    .run    (run),
    .hold   (hold),
    .idle   (idle),
    .scl_q  (scl_o),
    .rise_q (rise_stb),
    .fall_q (fall_stb)
  );

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (!idle && $past(!idle)) |-> $stable(cfg_q));
  assert_split_balance_R7: assert property (@(posedge clk) disable iff (rst)
    sel_ratio |-> ((pk_cfg.hi == pk_cfg.lo) || (pk_cfg.hi == pk_cfg.lo + CNT_W'(1))));
  assert_split_lo_min_R7: assert property (@(posedge clk) disable iff (rst)
    sel_ratio |-> (pk_cfg.lo != '0));
  assert_halving_R6: assert property (@(posedge clk) disable iff (rst)
    (sel_ratio && ratio >= RATIO_W'(16)) |-> (pk_cfg.ex != '0));
endmodule

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;
  localparam int RW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          sel = 1'b0;
  logic          stretch = 1'b0;
  logic [11:0]   word = '0;
  logic [RW-1:0] ratio = '0;
  logic          scl_o, rise, fall;
  logic          scl_in;
  int            n_chk = 0;
  int            n_bad = 0;

  assign scl_in = scl_o & ~stretch;

  always #5 clk = ~clk;

  scl_timing_gen #(.RATIO_W(RW)) u0 (
    .clk(clk), .rst(rst), .en(en), .sel_ratio(sel), .tim_word(word),
    .ratio(ratio), .scl_in(scl_in), .scl_o(scl_o), .rise_stb(rise), .fall_stb(fall)
  );

  task automatic chk(input bit ok, input string msg, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, expv);
    end
  endtask

  // Expected phase lengths in system cycles from a raw ratio (R6, R7).
  task automatic ratio_len(input int rin, output int lc, output int hc);
    int r, e, lo, hi;
    bit sticky;
    r = rin; e = 0; sticky = 0;
    while (r >= 16) begin
      sticky = sticky | r[0];
      r = r >> 1;
      e++;
    end
    r = r + int'(sticky);
    if (r < 4) r = 4;
    lo = r / 2 - 1;
    hi = r - lo - 2;
    lc = (lo + 1) << e;
    hc = (hi + 1) << e;
  endtask

  task automatic run_case(input int lc, input int hc, input int sh, input int sl,
                          input bit perturb, input string tag);
    int lowc, highc, kk, guard;
    bit extra;
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    chk(fall && !scl_o, {tag, " R3 fall at start"}, int'(fall), 1);
    for (int p = 0; p < 2; p++) begin
      lowc = 1; extra = 0; guard = 0; kk = sl;
      if (kk > 0) stretch = 1'b1;
      if (perturb && p == 0) begin
        word = ~word;
        ratio = ratio + RW'(777);
        sel = ~sel;
      end
      forever begin
        @(negedge clk);
        if (kk > 0) begin kk--; if (kk == 0) stretch = 1'b0; end
        guard++;
        if (scl_o || guard > 70000) break;
        lowc++;
        if (fall || rise) extra = 1;
      end
      chk(rise && !extra, {tag, " R5 rise strobe"}, int'(rise), 1);
      chk(lowc == lc, {tag, " R3/R8 low cycles"}, lowc, lc);
      highc = 1; extra = 0; guard = 0; kk = sh;
      if (kk > 0) stretch = 1'b1;
      forever begin
        @(negedge clk);
        if (kk > 0) begin kk--; if (kk == 0) stretch = 1'b0; end
        guard++;
        if (!scl_o || guard > 70000) break;
        highc++;
        if (fall || rise) extra = 1;
      end
      chk(fall && !extra, {tag, " R5 fall strobe"}, int'(fall), 1);
      chk(highc == hc + sh, {tag, " R4/R8 high cycles"}, highc, hc + sh);
    end
    en = 1'b0;
    @(negedge clk);
    chk(scl_o && rise, {tag, " R10 release with rise"}, int'(scl_o && rise), 1);
    @(negedge clk);
    chk(scl_o && !rise && !fall, {tag, " R1 idle"}, int'(scl_o), 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic packed_case(input int ex, input int lo, input int hi, input int sh,
                             input int sl, input bit perturb, input string tag);
    sel = 1'b0;
    word = {4'(hi), 4'(lo), 4'(ex)};
    run_case((lo + 1) << ex, (hi + 1) << ex, sh, sl, perturb, tag);
  endtask

  task automatic ratio_case(input int rv, input bit perturb, input string tag);
    int lc, hc;
    sel = 1'b1;
    ratio = RW'(rv);
    ratio_len(rv, lc, hc);
    run_case(lc, hc, 0, 0, perturb, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(scl_o && !rise && !fall, "R1 reset state", int'(scl_o), 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(scl_o && !rise && !fall, "R1 idle after reset", int'(scl_o), 1);

    packed_case(0, 1, 1, 0, 0, 0, "R2 word e0");
    packed_case(2, 3, 5, 0, 0, 0, "R2 word e2");
    packed_case(0, 0, 0, 0, 0, 0, "R2 word zero counts");
    packed_case(3, 15, 15, 0, 0, 0, "R2 word max counts");
    packed_case(1, 2, 2, 5, 0, 0, "R8 stretch high");
    packed_case(1, 2, 2, 0, 3, 0, "R8 stretch in low ignored");
    packed_case(1, 1, 3, 0, 0, 1, "R9 word change ignored");

    ratio_case(2, 0, "R7 clamp small");
    ratio_case(4, 0, "R7 ratio 4");
    ratio_case(15, 0, "R7 ratio 15");
    ratio_case(16, 0, "R6 ratio 16");
    ratio_case(17, 0, "R6 round 17");
    ratio_case(31, 0, "R6 round 31");
    ratio_case(300, 0, "R6 ratio 300");
    ratio_case(250, 1, "R9 ratio change ignored");

    for (int i = 0; i < 12; i++) begin
      packed_case(int'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
                  int'($urandom_range(0, 15)), int'($urandom_range(0, 4)), 0, 0,
                  "R4 random word");
      ratio_case(int'($urandom_range(0, 1500)), 0, "R6 random ratio");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule